// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Held Active Number

This block gathers a parameterised number of level-sensitive interrupt inputs (96 by default, in banks of 32) and drives one request line to a processor. Software reaches it through a simple 32-bit register bus with address, write data, write strobe, read strobe and combinational read data. Each source can be masked or unmasked on its own through a pair of write-only registers per bank. One register sets mask bits and the other clears them, so no read-modify-write is ever needed. The masked pending state of every bank can be read back.

When nothing is held and some unmasked source is high, the controller latches the lowest-numbered such source as the active number and raises the request line. It keeps that number until software writes the acknowledge bit. A read of the active register reports the number. If the held source has meanwhile dropped or been masked, the read returns a spurious marker in the upper bits instead. A version register, a stored autoidle bit and a self-timed soft reset with a done flag complete the map.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every source is masked, `cpu_irq` is low, the status register at 0x014 reads bit 0 = 1, and the version register at 0x000 reads major number in bits [7:4] and minor number in bits [3:0] with all other bits 0.
- R2: A write to the mask-set register of bank b (0x08C + 0x20*b) masks source 32*b+n for every bit n written as 1; bits written as 0 leave their mask unchanged.
- R3: A write to the mask-clear register of bank b (0x088 + 0x20*b) unmasks source 32*b+n for every bit n written as 1; bits written as 0 leave their mask unchanged.
- R4: The pending register of bank b (0x098 + 0x20*b) reads, in bit n, the input level of source 32*b+n ANDed with its unmasked state, and it follows the inputs with no storage.
- R5: When no number is held and at least one source is unmasked and high, the lowest such source number is latched at the next clock edge and `cpu_irq` rises on that same edge. The number and `cpu_irq` then stay unchanged until an acknowledge or soft reset, even if other sources change.
- R6: A write to the control register (0x048) with bit 0 = 1 releases the held number, and `cpu_irq` is low in the following cycle. Sorting resumes one cycle later. A control write with bit 0 = 0 has no effect.
- R7: The active register (0x040) reads the held number in bits [6:0] with bits [31:7] zero while the held source is still unmasked and high. Otherwise it reads all ones in bits [31:7] with the last latched number (0 after reset) in bits [6:0].
- R8: Bit 0 of the configuration register (0x010) is a stored autoidle bit that reads back as written; it resets to 0.
- R9: Writing 1 to bit 1 of the configuration register starts a soft reset. For RST_CYCLES cycles after that write, status bit 0 reads 0, all state holds its reset value and bus writes are ignored. Afterwards status bit 0 reads 1.
- R10: Reads of unmapped addresses and of the write-only mask registers return 0, and `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_rdata | output | 32 | Combinational read data |
| irq_src | input | NUM_SRC | Level-sensitive interrupt inputs |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default 96 sources, so all three banks and the highest bank offsets (0x0C8/0x0CC/0x0D8) are exercised. This lets the lowest-number search cross bank boundaries. RST_CYCLES is raised to 6 so that the busy window of the soft reset is long enough for the bench to read the status bit low and to land an ignored mask write inside it. The version fields are set to distinct non-zero values so that a swapped nibble shows.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_VERSION = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ACTIVE  = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_MCLR    = 12'h088;
  localparam logic [ADDR_W-1:0] OFS_MSET    = 12'h08C;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 12'h098;
  localparam int                BANK_STEP   = 32;

  // Address of a banked register: base plus one stride per bank.
  function automatic logic [ADDR_W-1:0] bank_ofs(input logic [ADDR_W-1:0] base,
                                                  input int unsigned b);
    return base + ADDR_W'(b * BANK_STEP);
  endfunction

  // Active-register word when the held source is no longer valid.
  function automatic logic [DATA_W-1:0] spurious_word(input logic [6:0] id);
    return {25'h1FF_FFFF, id};
  endfunction
endpackage

// File: rtl/lic_mask_bank.sv
module lic_mask_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_all,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] src,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (force_all) mask_q <= '1;
    else if (set_we)    mask_q <= mask_q | wdata;
    else if (clr_we)    mask_q <= mask_q & ~wdata;
  end

  assign pend = src & ~mask_q;
endmodule

// File: rtl/lic_sorter.sv
module lic_sorter #(
  parameter int NUM_SRC = 96,
  parameter int ID_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               ack,
  input  logic [NUM_SRC-1:0] pend,
  output logic               held,
  output logic [ID_W-1:0]    act_id,
  output logic [ID_W-1:0]    next_id,
  output logic               latch_evt
);
  function automatic logic [ID_W-1:0] lowest_id(input logic [NUM_SRC-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = ID_W'(i);
    return r;
  endfunction

  assign next_id   = lowest_id(pend);
  assign latch_evt = !flush && !held && (|pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      act_id <= '0;
    end else if (flush) begin
      held   <= 1'b0;
      act_id <= '0;
    end else if (held && ack) begin
      held <= 1'b0;
    end else if (latch_evt) begin
      held   <= 1'b1;
      act_id <= next_id;
    end
  end
endmodule

// File: rtl/lic_soft_reset.sv
module lic_soft_reset #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= CNT_W'(RST_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NUM_SRC    = 96,
  parameter int RST_CYCLES = 4,
  parameter int VER_MAJOR  = 2,
  parameter int VER_MINOR  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               cpu_irq
);
  import lic_pkg::*;

  localparam int BANK_W    = DATA_W;
  localparam int NUM_BANKS = NUM_SRC / BANK_W;
  localparam int ID_W      = $clog2(NUM_SRC);

  // Named internal events, also used by the checker.
  logic               wr_ok, ack_evt, srst_start, srst_busy, flush;
  logic               held, latch_evt, autoidle_q;
  logic [ID_W-1:0]    act_id, next_id;
  logic [NUM_SRC-1:0] mask_all, pend;
  logic [6:0]         id7;

  assign wr_ok      = bus_wr && !srst_busy;
  assign srst_start = wr_ok && (bus_addr == OFS_CFG) && bus_wdata[1];
  assign ack_evt    = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[0];
  assign flush      = srst_busy || srst_start;

  lic_soft_reset #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(srst_busy)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic set_we, clr_we;
    assign set_we = wr_ok && (bus_addr == bank_ofs(OFS_MSET, b));
    assign clr_we = wr_ok && (bus_addr == bank_ofs(OFS_MCLR, b));
    lic_mask_bank #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .force_all(flush),
      .set_we(set_we), .clr_we(clr_we), .wdata(bus_wdata),
      .src(irq_src[b*BANK_W +: BANK_W]),
      .mask_q(mask_all[b*BANK_W +: BANK_W]),
      .pend(pend[b*BANK_W +: BANK_W])
    );
  end

  lic_sorter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_sort (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ack(ack_evt), .pend(pend),
    .held(held), .act_id(act_id), .next_id(next_id), .latch_evt(latch_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             autoidle_q <= 1'b0;
    else if (flush)                         autoidle_q <= 1'b0;
    else if (wr_ok && bus_addr == OFS_CFG)  autoidle_q <= bus_wdata[0];
  end

  assign cpu_irq = held;
  assign id7     = 7'(act_id);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_VERSION: bus_rdata = {24'h0, 4'(VER_MAJOR), 4'(VER_MINOR)};
        OFS_CFG:     bus_rdata = {31'h0, autoidle_q};
        OFS_STAT:    bus_rdata = {31'h0, !srst_busy};
        OFS_ACTIVE:  bus_rdata = (held && pend[act_id]) ? {25'h0, id7}
                                                        : spurious_word(id7);
        default: begin
          for (int b = 0; b < NUM_BANKS; b++)
            if (bus_addr == bank_ofs(OFS_PEND, b))
              bus_rdata = pend[b*BANK_W +: BANK_W];
        end
      endcase
    end
  end
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int NUM_SRC = 96,
  parameter int ID_W    = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_irq,
  input logic               ack_evt,
  input logic               latch_evt,
  input logic               srst_start,
  input logic               srst_busy,
  input logic [NUM_SRC-1:0] mask_all,
  input logic [NUM_SRC-1:0] pend,
  input logic [ID_W-1:0]    act_id,
  input logic [ID_W-1:0]    next_id,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_wdata
);
  a_r5_hold_number: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && !ack_evt && !srst_start && !srst_busy |=> cpu_irq && $stable(act_id));

  a_r5_latch_raises: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> cpu_irq);

  a_r5_choice_pending: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |-> pend[next_id]);

  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && ack_evt |=> !cpu_irq);

  a_r9_busy_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (&mask_all) && !cpu_irq);

  a_r2_set_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !srst_busy && bus_addr == 12'h08C
      |=> (mask_all[31:0] & $past(bus_wdata)) == $past(bus_wdata));
endmodule

bind lvl_irq_ctrl lic_checker #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .ack_evt(ack_evt),
  .latch_evt(latch_evt), .srst_start(srst_start), .srst_busy(srst_busy),
  .mask_all(mask_all), .pend(pend), .act_id(act_id), .next_id(next_id),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/lvl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_bench;
  localparam int NSRC = 96;
  localparam int NB   = NSRC / 32;
  localparam int RSTC = 6;
  localparam int MAJ  = 3;
  localparam int MIN  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]     bus_rdata;
  logic [NSRC-1:0] irq_src = '0;
  logic            cpu_irq;

  int tests = 0, fails = 0;
  logic [NSRC-1:0] m_mask = '1;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(NSRC), .RST_CYCLES(RSTC), .VER_MAJOR(MAJ), .VER_MINOR(MIN))
    u_lvl_irq_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
                    .irq_src(irq_src), .cpu_irq(cpu_irq));

  function automatic logic [11:0] a_set(int b);  return 12'(12'h08C + b*32); endfunction
  function automatic logic [11:0] a_clr(int b);  return 12'(12'h088 + b*32); endfunction
  function automatic logic [11:0] a_pend(int b); return 12'(12'h098 + b*32); endfunction
  function automatic int lowest(logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction
  function automatic logic [31:0] ok_word(int id);  return 32'(id); endfunction
  function automatic logic [31:0] bad_word(int id); return 32'hFFFF_FF80 | 32'(id); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata; bus_rd = 1'b0;
  endtask
  task automatic mset(int b, logic [31:0] d);
    wr(a_set(b), d); m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | d;
  endtask
  task automatic mclr(int b, logic [31:0] d);
    wr(a_clr(b), d); m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~d;
  endtask
  task automatic chk_pend(string req);
    logic [31:0] d;
    logic [NSRC-1:0] p;
    p = irq_src & ~m_mask;
    for (int b = 0; b < NB; b++) begin
      rd(a_pend(b), d); check(req, d, p[b*32 +: 32]);
    end
  endtask
  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int exp_id;
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    irq_src = '1;
    rd(12'h000, d); check("R1 version", d, 32'(MAJ * 16 + MIN));
    rd(12'h014, d); check("R1 status", d, 32'h1);
    chk_pend("R1 all masked");
    check("R1 irq low", 32'(cpu_irq), 0);
    rd(12'h040, d); check("R7 none held", d, bad_word(0));
    irq_src = '0;

    // R3 / R4 / R5 across banks
    mclr(1, 32'h20); mclr(2, 32'h1);
    irq_src[64] = 1'b1;
    chk_pend("R4 bank2 level");
    check("R5 irq up", 32'(cpu_irq), 1);
    rd(12'h040, d); check("R7 id 64", d, ok_word(64));
    irq_src[37] = 1'b1;
    @(negedge clk);
    rd(12'h040, d); check("R5 held despite lower", d, ok_word(64));
    wr(12'h048, 32'h1);
    check("R6 irq drops", 32'(cpu_irq), 0);
    @(negedge clk);
    check("R6 resort irq", 32'(cpu_irq), 1);
    rd(12'h040, d); check("R5 lowest 37", d, ok_word(37));

    // R7 spurious, R6 zero write
    irq_src[37] = 1'b0;
    rd(12'h040, d); check("R7 spurious", d, bad_word(37));
    wr(12'h048, 32'h2);
    check("R6 bit0 zero ignored", 32'(cpu_irq), 1);
    wr(12'h048, 32'h1); @(negedge clk);
    rd(12'h040, d); check("R5 relatch 64", d, ok_word(64));

    // R2 / R3 zero bits
    mset(2, 32'h0);  chk_pend("R2 zero bits");
    mset(2, 32'h1);  chk_pend("R2 masks");
    rd(12'h040, d); check("R7 masked held", d, bad_word(64));
    mclr(2, 32'h0);  chk_pend("R3 zero bits");

    // R8 autoidle
    wr(12'h010, 32'h1); rd(12'h010, d); check("R8 set", d, 32'h1);
    wr(12'h010, 32'h0); rd(12'h010, d); check("R8 clear", d, 32'h0);

    // R10
    rd(12'h004, d); check("R10 unmapped", d, 0);
    rd(a_set(0), d); check("R10 write-only", d, 0);
    @(negedge clk); bus_addr = 12'h000; #1; check("R10 rd low", bus_rdata, 0);

    // R9 soft reset
    wr(12'h048, 32'h1);
    mclr(0, 32'hFFFF_FFFF); irq_src = '1; wr(12'h010, 32'h1);
    wr(12'h010, 32'h3);
    m_mask = '1;
    rd(12'h014, d); check("R9 busy", d, 32'h0);
    wr(a_clr(1), 32'hFFFF_FFFF);
    repeat (RSTC) @(negedge clk);
    rd(12'h014, d); check("R9 done", d, 32'h1);
    chk_pend("R9 masks restored, write ignored");
    rd(12'h010, d); check("R9 autoidle default", d, 32'h0);
    check("R9 irq low", 32'(cpu_irq), 0);
    irq_src = '0;

    // Random
    for (int it = 0; it < 40; it++) begin
      for (int b = 0; b < NB; b++) mset(b, 32'hFFFF_FFFF);
      irq_src = '0;
      wr(12'h048, 32'h1);
      for (int b = 0; b < NB; b++) mclr(b, $urandom & $urandom);
      irq_src = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      @(negedge clk); @(negedge clk);
      exp_id = lowest(irq_src & ~m_mask);
      chk_pend("R4 random");
      check("R5 random irq", 32'(cpu_irq), (exp_id >= 0) ? 1 : 0);
      rd(12'h040, d);
      if (exp_id >= 0) check("R7 random id", d, ok_word(exp_id));
    end

    summary();
    $finish;
  end
endmodule